// File: doc/BRIEF.md
# Binary Image Parallel Shrinker

This block reduces every 4-connected object of a small binary picture to one pixel, so that the number of objects can be read off as a pixel count. The picture is fed in one bit per clock on a serial input with a valid strobe, in row-major order from the top-left pixel. It is held in an on-chip shift register. A start pulse then launches the iterations. In each iteration all pixels are rewritten at once from the previous picture, and the cycle count of a run therefore depends only on the shape of the picture.

The shrink step applies a nested unit step h(x) = 1 for x > 0, else 0, to the pixel b and its north (N), west (W) and north-west (NW) neighbours: b' = h(h(b+N+W-1) + h(b+NW-1)). Neighbours outside the frame read as 0. Objects therefore collapse towards their lower-right corner. A pixel that is set and has none of its four edge neighbours set has become a lone survivor. That pixel is moved out of the working picture into a survivor picture, where it can never be deleted and no longer steers its neighbours. The run ends when the working picture is empty, or after ROWS+COLS iterations at most. The block then presents the union of both pictures and its population count, which is the object count.

Top module: `img_shrinker`

## Requirements
- R1: While no run is in progress, each cycle with `pix_valid` high shifts `pix_in` in. After ROWS*COLS strobes, the k-th pixel sent (k from 0, row-major from the top-left) appears on `image[k]`, where bit index r*COLS+c holds row r, column c.
- R2: One iteration rewrites every pixel at once from the previous picture. A set pixel with no set north, south, west or east neighbour moves to the survivor picture. Every other pixel becomes 1 when at least two of {b, N, W} are 1, or when b and NW are both 1, and becomes 0 otherwise. Out-of-frame neighbours read as 0. `image` shows the survivor picture ORed with the working picture after every iteration.
- R3: A pixel placed in the survivor picture stays set until the next load. In particular, every pixel that is already lone in the loaded picture is set in the result.
- R4: A start accepted at clock edge E0 runs one iteration at each of the edges E1, E2, and so on. `done` rises after the edge of the iteration that leaves the working picture empty, or after iteration ROWS+COLS, whichever comes first.
- R5: While `done` is high, `obj_count` equals the number of set bits of `image`.
- R6: A `start` pulse during a run has no effect on the result or on the cycle in which `done` rises.
- R7: `pix_valid` during a run has no effect on the result.
- R8: A `start` in the same cycle as the last pixel strobe is accepted, and the run processes the picture including that last pixel.
- R9: Synchronous active-high reset clears `done`, `image` and `obj_count`.
- R10: Two 2x2 squares at rows/columns 0-1 and 2-3 reduce to exactly two pixels, at (1,1) and (3,3), after 6 iterations.
- R11: `done` stays high with `image` unchanged until a `start` (which begins a new run) or a `pix_valid` strobe (which drops `done` at that edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 1 | Serial pixel value |
| pix_valid | input | 1 | Strobe that shifts `pix_in` in |
| start | input | 1 | Begins a run when no run is in progress |
| done | output | 1 | Run finished, result valid |
| image | output | ROWS*COLS | Picture, bit r*COLS+c = row r, column c |
| obj_count | output | clog2(ROWS*COLS+1) | Set-pixel count of `image` |

## Verification
Two events can share a clock edge: the last pixel strobe together with the start pulse, and a start or pixel strobe together with the final iteration of a run. The first is provoked by raising `start` on the last pixel of a load. It is judged by comparing the result against a model run on the complete picture. The second is provoked by random start and pixel strobes during runs, which inevitably land on the finishing edge as well. It is judged by requiring that `done` rises in exactly the modelled iteration and that the result is undisturbed.

// File: rtl/img_shrink_pkg.sv
package img_shrink_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } shr_state_e;

    // one pixel and the neighbours the iteration looks at
    typedef struct packed {
        logic ctr;
        logic nth;
        logic sth;
        logic wst;
        logic est;
        logic nwt;
    } nbhd_t;

    function automatic logic step_h(input int x);
        return (x > 0);
    endfunction

    function automatic logic is_lone(input nbhd_t p);
        return p.ctr & ~p.nth & ~p.sth & ~p.wst & ~p.est;
    endfunction

    function automatic logic shrink_bit(input nbhd_t p);
        int a;
        int b;
        a = int'(p.ctr) + int'(p.nth) + int'(p.wst) - 1;
        b = int'(p.ctr) + int'(p.nwt) - 1;
        return step_h(int'(step_h(a)) + int'(step_h(b)));
    endfunction

endpackage

// File: rtl/shrink_array.sv
module shrink_array
    import img_shrink_pkg::*;
#(
    parameter int ROWS = 6,
    parameter int COLS = 6,
    localparam int NPIX = ROWS * COLS
) (
    input  logic [NPIX-1:0] work,
    input  logic [NPIX-1:0] keep,
    output logic [NPIX-1:0] nxt_work,
    output logic [NPIX-1:0] nxt_keep,
    output logic            nxt_empty
);

    logic pad [0:ROWS+1][0:COLS+1];

    always_comb begin
        for (int r = 0; r < ROWS + 2; r++) begin
            for (int c = 0; c < COLS + 2; c++) begin
                pad[r][c] = 1'b0;
            end
        end
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                pad[r+1][c+1] = work[r*COLS + c];
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            nbhd_t nb;
            logic  lone;
            assign nb.ctr = pad[r+1][c+1];
            assign nb.nth = pad[r][c+1];
            assign nb.sth = pad[r+2][c+1];
            assign nb.wst = pad[r+1][c];
            assign nb.est = pad[r+1][c+2];
            assign nb.nwt = pad[r][c];
            assign lone   = is_lone(nb);
            assign nxt_work[r*COLS + c] = ~lone & shrink_bit(nb);
            assign nxt_keep[r*COLS + c] = keep[r*COLS + c] | lone;
        end
    end

    assign nxt_empty = (nxt_work == '0);

endmodule

// File: rtl/bit_counter.sv
module bit_counter #(
    parameter int W  = 36,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/shrink_ctrl.sv
module shrink_ctrl
    import img_shrink_pkg::*;
#(
    parameter int MAX_ITER = 12,
    localparam int IT_W = $clog2(MAX_ITER + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            pix_valid,
    input  logic            nxt_empty,
    output logic            busy,
    output logic            done,
    output logic [IT_W-1:0] iter
);

    shr_state_e state_q;
    logic [IT_W-1:0] iter_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
            iter_q  <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        iter_q  <= '0;
                    end
                end
                ST_RUN: begin
                    iter_q <= iter_q + 1'b1;
                    if (nxt_empty || iter_q == IT_W'(MAX_ITER - 1)) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        iter_q  <= '0;
                    end else if (pix_valid) begin
                        state_q <= ST_LOAD;
                    end
                end
                default: state_q <= ST_LOAD;
            endcase
        end
    end

    assign busy = (state_q == ST_RUN);
    assign done = (state_q == ST_DONE);
    assign iter = iter_q;

endmodule

// File: rtl/img_shrinker.sv
module img_shrinker #(
    parameter int ROWS = 6,
    parameter int COLS = 6,
    localparam int NPIX  = ROWS * COLS,
    localparam int CNT_W = $clog2(NPIX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_in,
    input  logic             pix_valid,
    input  logic             start,
    output logic             done,
    output logic [NPIX-1:0]  image,
    output logic [CNT_W-1:0] obj_count
);

    localparam int MAX_ITER = ROWS + COLS;
    localparam int IT_W     = $clog2(MAX_ITER + 1);

    logic [NPIX-1:0] work_q, keep_q;
    logic [NPIX-1:0] nxt_work, nxt_keep;
    logic            nxt_empty;
    logic            busy;
    logic [IT_W-1:0] iter;

    shrink_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
        .work      (work_q),
        .keep      (keep_q),
        .nxt_work  (nxt_work),
        .nxt_keep  (nxt_keep),
        .nxt_empty (nxt_empty)
    );

    shrink_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pix_valid (pix_valid),
        .nxt_empty (nxt_empty),
        .busy      (busy),
        .done      (done),
        .iter      (iter)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            keep_q <= '0;
        end else if (busy) begin
            work_q <= nxt_work;
            keep_q <= nxt_keep;
        end else if (pix_valid) begin
            work_q <= {pix_in, work_q[NPIX-1:1]};
            keep_q <= '0;
        end
    end

    assign image = work_q | keep_q;

    bit_counter #(.W(NPIX)) u_count (
        .vec (image),
        .cnt (obj_count)
    );

endmodule

// File: rtl/img_shrinker_chk.sv
module img_shrinker_chk #(
    parameter int ROWS = 6,
    parameter int COLS = 6,
    localparam int NPIX     = ROWS * COLS,
    localparam int CNT_W    = $clog2(NPIX + 1),
    localparam int MAX_ITER = ROWS + COLS,
    localparam int IT_W     = $clog2(MAX_ITER + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             pix_valid,
    input logic             done,
    input logic             busy,
    input logic [NPIX-1:0]  image,
    input logic [NPIX-1:0]  keep_img,
    input logic [CNT_W-1:0] obj_count,
    input logic [IT_W-1:0]  iter
);

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && image == '0 && obj_count == '0));

    // R4
    run_to_done_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    // R4
    iter_cap_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (iter <= IT_W'(MAX_ITER - 1)));

    // R3
    keep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((keep_img & $past(keep_img)) == $past(keep_img)));

    // R5
    count_match_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (obj_count == CNT_W'($countones(image))));

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (iter == $past(iter) + 1'b1));

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start && !pix_valid) |=> (done && $stable(image)));

endmodule

bind img_shrinker img_shrinker_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pix_valid (pix_valid),
    .done      (done),
    .busy      (busy),
    .image     (image),
    .keep_img  (keep_q),
    .obj_count (obj_count),
    .iter      (iter)
);

// File: tb/img_shrinker_bench.sv
module img_shrinker_bench;

    localparam int ROWS  = 6;
    localparam int COLS  = 6;
    localparam int NPIX  = ROWS * COLS;
    localparam int CNT_W = $clog2(NPIX + 1);
    localparam int MAXI  = ROWS + COLS;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pix_in = 1'b0;
    logic             pix_valid = 1'b0;
    logic             start = 1'b0;
    logic             done;
    logic [NPIX-1:0]  image;
    logic [CNT_W-1:0] obj_count;

    int n_chk = 0;
    int n_err = 0;
    bit wd_hit = 1'b0;

    img_shrinker #(.ROWS(ROWS), .COLS(COLS)) u_img_shrinker (
        .clk, .rst, .pix_in, .pix_valid, .start, .done, .image, .obj_count
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic pxl(input logic [NPIX-1:0] v, input int r, input int c);
        if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 1'b0;
        return v[r*COLS + c];
    endfunction

    function automatic void model(input logic [NPIX-1:0] img, output logic [NPIX-1:0] fin,
                                  output logic [NPIX-1:0] first, output int its);
        logic [NPIX-1:0] w, k, w2, k2;
        w = img; k = '0; its = 0; first = '0;
        for (int it = 0; it < MAXI; it++) begin
            w2 = '0; k2 = k;
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    logic cb, n, s, wv, e, nwv;
                    cb = pxl(w, r, c);     n = pxl(w, r-1, c); s = pxl(w, r+1, c);
                    wv = pxl(w, r, c-1);   e = pxl(w, r, c+1); nwv = pxl(w, r-1, c-1);
                    if (cb && !n && !s && !wv && !e) k2[r*COLS+c] = 1'b1;
                    else w2[r*COLS+c] = ((int'(cb) + int'(n) + int'(wv)) >= 2) || (cb && nwv);
                end
            end
            w = w2; k = k2; its++;
            if (its == 1) first = w | k;
            if (w == '0) break;
        end
        fin = w | k;
    endfunction

    function automatic logic [NPIX-1:0] lone_of(input logic [NPIX-1:0] v);
        logic [NPIX-1:0] o;
        o = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                o[r*COLS+c] = pxl(v,r,c) & ~pxl(v,r-1,c) & ~pxl(v,r+1,c) & ~pxl(v,r,c-1) & ~pxl(v,r,c+1);
        return o;
    endfunction

    task automatic run_case(input logic [NPIX-1:0] img, input bit disturb, input bit merge,
                            output logic [NPIX-1:0] got);
        logic [NPIX-1:0] fin, first;
        int its, cyc;
        model(img, fin, first, its);
        for (int k = 0; k < NPIX; k++) begin
            pix_valid = 1'b1;
            pix_in    = img[k];
            if (merge && k == NPIX - 1) start = 1'b1;
            @(negedge clk);
        end
        pix_valid = 1'b0;
        if (merge) begin
            start = 1'b0;
        end else begin
            chk(image == img, "R1 loaded image", 64'(image), 64'(img));
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 4 * MAXI) begin
            if (disturb) begin
                pix_valid = 1'($urandom % 2);
                pix_in    = 1'($urandom % 2);
                start     = 1'($urandom % 2);
            end
            @(negedge clk);
            pix_valid = 1'b0;
            start     = 1'b0;
            cyc++;
            if (cyc == 1) chk(image == first, "R2 first iteration", 64'(image), 64'(first));
        end
        chk(cyc == its, disturb ? "R6 R4 done cycle" : (merge ? "R8 done cycle" : "R4 done cycle"),
            64'(cyc), 64'(its));
        chk(image == fin, disturb ? "R7 result under strobes" : (merge ? "R8 result" : "R2 result"),
            64'(image), 64'(fin));
        chk(obj_count == CNT_W'($countones(fin)), "R5 object count", 64'(obj_count), 64'($countones(fin)));
        chk((image & lone_of(img)) == lone_of(img), "R3 lone pixels kept", 64'(image), 64'(lone_of(img)));
        got = image;
    endtask

    initial begin
        int t;
        t = 0;
        while (t < 150000) begin
            @(posedge clk);
            t++;
        end
        wd_hit = 1'b1;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=<150000", t);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [NPIX-1:0] img, got, sq;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && image == '0 && obj_count == '0, "R9 reset state", 64'(image), 64'd0);

        // two 2x2 squares touching at one corner
        sq = '0;
        sq[0*COLS+0] = 1'b1; sq[0*COLS+1] = 1'b1; sq[1*COLS+0] = 1'b1; sq[1*COLS+1] = 1'b1;
        sq[2*COLS+2] = 1'b1; sq[2*COLS+3] = 1'b1; sq[3*COLS+2] = 1'b1; sq[3*COLS+3] = 1'b1;
        run_case(sq, 1'b0, 1'b0, got);
        img = '0; img[1*COLS+1] = 1'b1; img[3*COLS+3] = 1'b1;
        chk(got == img, "R10 two squares", 64'(got), 64'(img));
        chk(obj_count == CNT_W'(2), "R10 two objects", 64'(obj_count), 64'd2);

        // R11: done holds while idle, then a strobe drops it
        repeat (4) @(negedge clk);
        chk(done && image == got, "R11 done held", 64'(image), 64'(got));
        pix_valid = 1'b1; pix_in = 1'b0;
        @(negedge clk);
        pix_valid = 1'b0;
        chk(!done, "R11 strobe drops done", 64'(done), 64'd0);

        // single pixel in the last corner, empty frame, full frame
        img = '0; img[NPIX-1] = 1'b1;
        run_case(img, 1'b0, 1'b0, got);
        chk(got == img, "R3 single corner pixel", 64'(got), 64'(img));
        run_case('0, 1'b0, 1'b0, got);
        chk(got == '0 && obj_count == '0, "R4 empty frame", 64'(got), 64'd0);
        run_case('1, 1'b1, 1'b0, got);

        // start together with the last pixel
        run_case(sq, 1'b0, 1'b1, got);
        img = '0; img[0] = 1'b1; img[NPIX-1] = 1'b1;
        run_case(img, 1'b0, 1'b1, got);
        chk(got == img, "R8 last pixel included", 64'(got), 64'(img));

        for (int n = 0; n < 40; n++) begin
            img = '0;
            for (int k = 0; k < NPIX; k++) img[k] = (($urandom % 100) < 40);
            run_case(img, n[0], (n % 5) == 3, got);
        end

        if (!wd_hit) begin
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule